// File: doc/BRIEF.md
# Translation Table Bulk Transfer Sequencer

This block holds a 512-entry page translation table and runs one of three whole-table commands over it. A load command fills every entry, lowest index first, from a word stream that has valid/ready handshaking. A store command sends every entry out, in the same order, on a handshaked output stream. A scan command walks the table and emits one halfword for each entry whose written flag (entry bit 30) is clear. It then closes the list with an all-ones halfword. The surrounding processor uses the scan list to pick pages that can be replaced.

To issue a command, pulse `start` for one cycle with a code on `cmd` while the block is idle. `busy` stays high from the cycle after the start until the cycle after the last transfer of the command. Memory address generation and processor condition codes belong to the logic around this block.

Top module: `ttb_bulk_xfer`

## Requirements
- R1: After reset, `busy`, `in_ready` and `out_valid` are all low.
- R2: Command code 2'b01 (load) accepts exactly 512 words on the input stream. Word k of the stream is written to entry k unchanged, including bit 30. `in_ready` is high for the whole load.
- R3: Command code 2'b10 (store) emits all 512 entries as full 32-bit words, in ascending index order.
- R4: Command code 2'b11 (scan) emits one output word for each entry whose bit 30 is 0, in ascending index order. Bits 8:0 of that word hold the entry index and bits 31:9 are zero. An entry whose bit 30 is 1 produces no word.
- R5: After the last index, the scan emits one terminator word, 32'h0000FFFF. The terminator is emitted even when no entry qualifies.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high and an unchanged `out_data`. No word is lost or repeated.
- R7: `busy` stays high for the whole command. It is low in the cycle after the final word or terminator is accepted.
- R8: A start pulse while `busy` is high is ignored. A start pulse with command code 2'b00 leaves the block idle.
- R9: The store and scan commands leave the table contents unchanged.
- R10: `in_ready` is low except during a load. Input words offered at any other time are not written to the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command request |
| cmd | input | 2 | Command code: 00 none, 01 load, 10 store, 11 scan |
| in_valid | input | 1 | Input word offered |
| in_data | input | 32 | Input table entry |
| in_ready | output | 1 | Input word will be taken at this edge |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the output word at this edge |
| out_data | output | 32 | Table entry (store) or zero-extended halfword (scan) |
| busy | output | 1 | A command is in progress |

## Verification
`in_ready`, `out_valid` and `out_data` are combinational functions of the registered state. They are therefore valid in the first cycle after the start edge, and each handshake completes at the next rising edge. `busy` is the registered state, so it drops exactly one cycle after the final accepted transfer.

The bench drives inputs on the falling edge and samples outputs 1 ns later, in that same low phase. A transfer is counted when valid and ready are both seen high at that sample. The check that `busy` has dropped is made at the following falling edge. The ready and valid patterns insert gaps so that stalls occur on both streams.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_LOAD  = 2'b01,
        CMD_STORE = 2'b10,
        CMD_SCAN  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STORE,
        ST_SCAN,
        ST_TERM
    } state_e;

endpackage

// File: rtl/ttb_table.sv
module ttb_table #(
    parameter int DEPTH   = 512,
    parameter int ENTRY_W = 32,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   addr,
    input  logic [ENTRY_W-1:0] wdata,
    output logic [ENTRY_W-1:0] rdata
);

    logic [ENTRY_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/ttb_scan_fmt.sv
module ttb_scan_fmt #(
    parameter int ENTRY_W = 32,
    parameter int IDX_W   = 9,
    parameter int HALF_W  = 16,
    parameter int WR_BIT  = 30
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [IDX_W-1:0]   idx,
    input  logic               term,
    output logic               skip,
    output logic [ENTRY_W-1:0] word
);

    localparam int IDX_PAD  = ENTRY_W - IDX_W;
    localparam int HALF_PAD = ENTRY_W - HALF_W;

    // A set written flag means the page copy differs from backing store.
    assign skip = entry[WR_BIT];

    always_comb begin
        if (term) begin
            word = {{HALF_PAD{1'b0}}, {HALF_W{1'b1}}};
        end else begin
            word = {{IDX_PAD{1'b0}}, idx};
        end
    end

endmodule

// File: rtl/ttb_seq.sv
module ttb_seq
    import ttb_pkg::*;
#(
    parameter int DEPTH   = 512,
    parameter int ENTRY_W = 32,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         cmd,
    input  logic               in_valid,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ENTRY_W-1:0] out_data,
    output logic               busy,
    output logic               tbl_we,
    output logic [IDX_W-1:0]   tbl_addr,
    input  logic [ENTRY_W-1:0] tbl_rdata,
    output logic               term_sel,
    input  logic               fmt_skip,
    input  logic [ENTRY_W-1:0] fmt_word
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        state_e           st;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                nxt_d.idx = '0;
                if (start) begin
                    unique case (cmd)
                        CMD_LOAD:  nxt_d.st = ST_LOAD;
                        CMD_STORE: nxt_d.st = ST_STORE;
                        CMD_SCAN:  nxt_d.st = ST_SCAN;
                        default:   nxt_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_LOAD: begin
                if (in_valid) begin
                    nxt_d.idx = cur_q.idx + 1'b1;
                    if (cur_q.idx == LAST) nxt_d.st = ST_IDLE;
                end
            end
            ST_STORE: begin
                if (out_ready) begin
                    nxt_d.idx = cur_q.idx + 1'b1;
                    if (cur_q.idx == LAST) nxt_d.st = ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (fmt_skip || out_ready) begin
                    nxt_d.idx = cur_q.idx + 1'b1;
                    if (cur_q.idx == LAST) nxt_d.st = ST_TERM;
                end
            end
            ST_TERM: begin
                if (out_ready) nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, idx: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy      = (cur_q.st != ST_IDLE);
    assign in_ready  = (cur_q.st == ST_LOAD);
    assign tbl_we    = in_ready && in_valid;
    assign tbl_addr  = cur_q.idx;
    assign term_sel  = (cur_q.st == ST_TERM);
    assign out_valid = (cur_q.st == ST_STORE) || term_sel ||
                       ((cur_q.st == ST_SCAN) && !fmt_skip);
    assign out_data  = (cur_q.st == ST_STORE) ? tbl_rdata : fmt_word;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !in_ready));

    p_load_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cur_q.idx != LAST) |=> (cur_q.idx == $past(cur_q.idx) + 1'b1));

    p_term_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_SCAN && cur_q.idx == LAST && (fmt_skip || out_ready)) |=> (out_valid && term_sel));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cur_q.idx == LAST) |=> !busy);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cur_q.st == ST_STORE && !out_ready) |=> (cur_q.st == ST_STORE && !in_ready));

endmodule

// File: rtl/ttb_bulk_xfer.sv
module ttb_bulk_xfer #(
    parameter int DEPTH   = 512,
    parameter int ENTRY_W = 32,
    parameter int HALF_W  = 16,
    parameter int WR_BIT  = 30,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         cmd,
    input  logic               in_valid,
    input  logic [ENTRY_W-1:0] in_data,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ENTRY_W-1:0] out_data,
    output logic               busy
);

    logic               tbl_we;
    logic [IDX_W-1:0]   tbl_addr;
    logic [ENTRY_W-1:0] tbl_rdata;
    logic               term_sel;
    logic               fmt_skip;
    logic [ENTRY_W-1:0] fmt_word;

    ttb_table #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .addr  (tbl_addr),
        .wdata (in_data),
        .rdata (tbl_rdata)
    );

    ttb_scan_fmt #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .HALF_W(HALF_W), .WR_BIT(WR_BIT)) u_fmt (
        .entry (tbl_rdata),
        .idx   (tbl_addr),
        .term  (term_sel),
        .skip  (fmt_skip),
        .word  (fmt_word)
    );

    ttb_seq #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .busy      (busy),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_rdata (tbl_rdata),
        .term_sel  (term_sel),
        .fmt_skip  (fmt_skip),
        .fmt_word  (fmt_word)
    );

    // Only a load may change the table (R9, R10).
    p_write_only_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (in_ready && !out_valid));

endmodule

// File: tb/sim_ttb_bulk_xfer.sv
module sim_ttb_bulk_xfer;

    localparam int N = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        busy;

    logic [31:0] model [N];
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ttb_bulk_xfer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c);
        @(negedge clk);
        start = 1'b1;
        cmd   = c;
        @(negedge clk);
        start = 1'b0;
        cmd   = 2'b00;
    endtask

    function automatic logic [31:0] pat(input int kind, input int i);
        logic [31:0] v;
        v = (32'(i) * 32'h9E3779B1) ^ 32'h0F0F1234;
        case (kind)
            0: v[30] = (i % 3 != 0);
            1: v[30] = 1'b1;
            default: begin v[30] = 1'b0; v[31] = 1'b1; end
        endcase
        return v;
    endfunction

    task automatic test_reset();
        @(negedge clk);
        chk(!busy && !in_ready && !out_valid, "R1 reset outputs", {29'b0, busy, in_ready, out_valid}, 32'h0);
    endtask

    task automatic run_load(input int kind);
        int idx = 0;
        int cyc = 0;
        int miss_ready = 0;
        for (int i = 0; i < N; i++) model[i] = pat(kind, i);
        issue(2'b01);
        while (idx < N && cyc < 4 * N) begin
            in_valid = (cyc % 4 != 3);
            in_data  = model[idx];
            #1;
            if (!in_ready || !busy) miss_ready++;
            if (in_valid && in_ready) idx++;
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_data  = '0;
        chk(idx == N, "R2 words accepted", 32'(idx), 32'(N));
        chk(miss_ready == 0, "R2 in_ready/busy held during load", 32'(miss_ready), 32'h0);
        #1;
        chk(!busy && !in_ready, "R7 busy low after last load word", {30'b0, busy, in_ready}, 32'h0);
    endtask

    task automatic run_store(input bit inject);
        int got = 0;
        int cyc = 0;
        bit stall_prev = 1'b0;
        logic [31:0] prev_d = '0;
        int bad_ready = 0;
        issue(2'b10);
        while (got < N && cyc < 4 * N) begin
            out_ready = (cyc % 5 != 2);
            if (inject) begin
                start    = (cyc == 3) || (cyc == 200);
                cmd      = 2'b01;
                in_valid = 1'b1;
                in_data  = 32'hDEAD0000 ^ 32'(cyc);
            end
            #1;
            if (stall_prev)
                chk(out_valid && out_data == prev_d, "R6 store stall hold", out_data, prev_d);
            if (in_ready) bad_ready++;
            if (!busy) bad_ready++;
            if (out_valid && out_ready) begin
                chk(out_data == model[got], "R3 store word", out_data, model[got]);
                got++;
            end
            stall_prev = out_valid && !out_ready;
            prev_d     = out_data;
            cyc++;
            @(negedge clk);
            start = 1'b0;
            cmd   = 2'b00;
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk(got == N, "R3 store count", 32'(got), 32'(N));
        chk(bad_ready == 0, "R10 in_ready low and busy high in store", 32'(bad_ready), 32'h0);
        #1;
        chk(!busy && !out_valid, "R7 busy low after last store word", {30'b0, busy, out_valid}, 32'h0);
    endtask

    task automatic run_scan(input bit inject);
        logic [31:0] exp_list [N + 1];
        int exp_n = 0;
        int got = 0;
        int cyc = 0;
        bit stall_prev = 1'b0;
        logic [31:0] prev_d = '0;
        for (int i = 0; i < N; i++)
            if (!model[i][30]) begin
                exp_list[exp_n] = 32'(i);
                exp_n++;
            end
        exp_list[exp_n] = 32'h0000FFFF;
        exp_n++;
        issue(2'b11);
        while (got < exp_n && cyc < 4 * N + 40) begin
            out_ready = (cyc % 7 != 4);
            if (inject) begin
                start    = (cyc % 50 == 5);
                cmd      = 2'b10;
                in_valid = 1'b1;
                in_data  = 32'h0BAD0000 | 32'(cyc);
            end
            #1;
            if (stall_prev)
                chk(out_valid && out_data == prev_d, "R6 scan stall hold", out_data, prev_d);
            if (in_ready) chk(1'b0, "R10 in_ready in scan", 32'h1, 32'h0);
            if (out_valid && out_ready) begin
                if (got == exp_n - 1)
                    chk(out_data == exp_list[got], "R5 scan terminator", out_data, exp_list[got]);
                else
                    chk(out_data == exp_list[got], "R4 scan index word", out_data, exp_list[got]);
                got++;
            end
            stall_prev = out_valid && !out_ready;
            prev_d     = out_data;
            cyc++;
            @(negedge clk);
            start = 1'b0;
            cmd   = 2'b00;
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk(got == exp_n, "R4 scan list length", 32'(got), 32'(exp_n));
        #1;
        chk(!busy && !out_valid, "R7 busy low after terminator", {30'b0, busy, out_valid}, 32'h0);
    endtask

    task automatic test_idle_ignores();
        issue(2'b00);
        #1;
        chk(!busy, "R8 start with code none stays idle", {31'b0, busy}, 32'h0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'hFFFFFFFF;
        #1;
        chk(!in_ready, "R10 in_ready low while idle", {31'b0, in_ready}, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_load(0);
        run_store(1'b0);
        run_scan(1'b0);
        run_store(1'b1);   // R8 and R10: start and input words during store
        run_scan(1'b1);    // R8 and R10 during scan
        run_store(1'b0);   // R9: table unchanged by store and scan
        test_idle_ignores();
        run_store(1'b0);   // R10: idle input words not written
        run_load(1);
        run_scan(1'b0);    // R5: only the terminator
        run_load(2);
        run_scan(1'b0);    // R4: all indices through 511
        run_store(1'b0);   // R2: bit 30 kept as supplied
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule